// File: doc/BRIEF.md
# Receive Gain Control Loop

This block closes the digital side of a receive automatic gain loop. It watches the ADC sample stream in fixed windows of `WIN_LEN` valid samples. For each window it counts how many samples sit at the converter's rail codes and records the peak magnitude. At each window boundary it then moves an unsigned IF gain code, in 1 dB units, towards a target amplitude range. When the converter saturates often, the step is coarse. When it saturates a little, the step is medium. When there is no saturation at all, the step is a single unit. When a window arrives with no saturation and an amplitude inside the programmed lock range, the loop freezes its gain and raises a lock flag.

While the loop is locked, every window's peak is compared with the peak that was stored at lock. If the difference is larger than a programmed drift limit, lock is released and a one-cycle carrier-sense pulse is emitted. Adjustment then resumes from the next window onward. A separate front-end power indicator controls a low-noise amplifier bypass. A power value at or above an upper threshold turns the amplifier off, and the IF code rises by `LNA_DB` to compensate. A power value below a lower threshold turns it back on, and the IF code falls by the same amount. The bypass state never changes while the loop is locked.

The controller has three states. `S_IDLE` holds the reset gain. `S_ACQ` adjusts the gain. `S_LOCK` holds the gain frozen. The transitions between them are:
- `start`: `S_IDLE` to `S_ACQ`, taken when receive is enabled.
- `lock`: `S_ACQ` to `S_LOCK`, taken on an in-range window.
- `unlock`: `S_LOCK` to `S_ACQ`, taken on a drift window.
- `abort`: from any state to `S_IDLE`, taken whenever receive enable is low.

Top module: `agc_gain_ctrl`

## Requirements
- R1: While `rst_n` or `rx_en` is low, the outputs read `if_gain` = `GAIN_MAX`, `lna_on` = 1, `locked` = 0 and `cs_pulse` = 0. The same values hold on the first cycle after `rx_en` rises.
- R2: A window closes on every `WIN_LEN`-th valid sample. A sample counts as saturated when its code equals +2^(SAMP_W-1)-1 or -2^(SAMP_W-1). The window amplitude is the largest absolute sample value in the window. The partial window is cleared whenever `rx_en` is low.
- R3: In `S_ACQ`, with no lock and no bypass change, a window whose saturated count is at least `sat_big_thr` lowers `if_gain` by `BIG_STEP`.
- R4: In `S_ACQ`, with no lock and no bypass change, a window with a saturated count between 1 and `sat_big_thr`-1 lowers `if_gain` by `MID_STEP`.
- R5: In `S_ACQ`, with no lock and no bypass change, a window with no saturation lowers `if_gain` by 1 when its amplitude is above `lock_hi`, and raises it by 1 when its amplitude is below `lock_lo`.
- R6: In `S_ACQ`, a window with no saturation and `lock_lo` <= amplitude <= `lock_hi` sets `locked`, stores the amplitude, and leaves `if_gain` unchanged.
- R7: `if_gain`, `lna_on` and `locked` change only on the clock edge one cycle after the edge that captures the last sample of a window, or through R1.
- R8: While locked, `if_gain` and `lna_on` do not change. A window whose amplitude differs from the stored amplitude by no more than `drift_lim` (the boundary value included) keeps the lock.
- R9: While locked, a window whose amplitude differs from the stored amplitude by more than `drift_lim` clears `locked` and pulses `cs_pulse` high for exactly one cycle, with the gain unchanged. Adjustment resumes from the following window.
- R10: In `S_ACQ`, when `lna_on` = 1 and `rf_pwr` >= `rf_off_thr` at a window end, `lna_on` goes to 0 and `if_gain` rises by `LNA_DB`. No amplitude step is applied in that window.
- R11: In `S_ACQ`, when `lna_on` = 0 and `rf_pwr` < `rf_on_thr`, `lna_on` goes to 1 and `if_gain` falls by `LNA_DB`. A power value between the two thresholds leaves the bypass state as it is.
- R12: The lock test of R6 takes priority over the bypass change. An in-range window locks the loop even when `rf_pwr` is high, and it leaves `lna_on` unchanged.
- R13: Every change to `if_gain` is clamped to the range from `GAIN_MIN` to `GAIN_MAX`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable; low returns the block to idle |
| samp_valid | input | 1 | `samp` carries a new ADC sample |
| samp | input | SAMP_W | Signed ADC sample |
| rf_pwr | input | RF_W | Front-end power indicator |
| sat_big_thr | input | CNT_W | Saturated count that selects the coarse step |
| lock_lo | input | SAMP_W | Lower bound of the lock amplitude range |
| lock_hi | input | SAMP_W | Upper bound of the lock amplitude range |
| drift_lim | input | SAMP_W | Largest tolerated amplitude drift while locked |
| rf_off_thr | input | RF_W | Power at or above which the LNA is bypassed |
| rf_on_thr | input | RF_W | Power below which the LNA is restored |
| if_gain | output | GAIN_W | IF gain code in 1 dB units |
| lna_on | output | 1 | LNA enable |
| locked | output | 1 | Gain frozen |
| cs_pulse | output | 1 | One-cycle carrier-sense pulse on lock loss |

## Verification
The bench builds the block with its defaults: 16-sample windows, 8-bit samples, a 7-bit gain code from 0 to 90, coarse and medium steps of 12 and 4, and a 30-unit bypass swap. With these values, eight coarse windows drive the gain into the lower clamp. Starting from full gain, a bypass swap hits the upper clamp. A saturated window's amplitude of 127 always lies outside the lock range of 40 to 70, and a drift limit of 10 lets both sides of the drift boundary be reached with small peak changes.

// File: rtl/agc_pkg.sv
package agc_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ACQ,
        S_LOCK
    } agc_state_e;

    typedef enum logic [2:0] {
        ADJ_HOLD,
        ADJ_BIG,
        ADJ_MID,
        ADJ_FINE_DN,
        ADJ_FINE_UP
    } adj_e;

endpackage

// File: rtl/agc_win_stats.sv
module agc_win_stats #(
    parameter int WIN_LEN = 16,
    parameter int SAMP_W  = 8,
    parameter int CNT_W   = $clog2(WIN_LEN + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     valid,
    input  logic signed [SAMP_W-1:0] samp,
    output logic                     win_done,
    output logic [CNT_W-1:0]         sat_cnt,
    output logic [SAMP_W-1:0]        peak
);
    localparam int IDX_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam logic signed [SAMP_W-1:0] RAIL_HI = {1'b0, {(SAMP_W-1){1'b1}}};
    localparam logic signed [SAMP_W-1:0] RAIL_LO = {1'b1, {(SAMP_W-1){1'b0}}};

    logic [IDX_W-1:0]  idx;
    logic [CNT_W-1:0]  acc_sat;
    logic [SAMP_W-1:0] acc_peak;
    logic              is_sat;
    logic [SAMP_W-1:0] mag;
    logic [CNT_W-1:0]  sat_nx;
    logic [SAMP_W-1:0] peak_nx;
    logic              last;

    always_comb begin
        is_sat  = (samp == RAIL_HI) || (samp == RAIL_LO);
        mag     = samp[SAMP_W-1] ? (~samp + 1'b1) : samp;
        sat_nx  = acc_sat + CNT_W'(is_sat);
        peak_nx = (mag > acc_peak) ? mag : acc_peak;
        last    = (idx == IDX_W'(WIN_LEN - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx      <= '0;
            acc_sat  <= '0;
            acc_peak <= '0;
            win_done <= 1'b0;
            sat_cnt  <= '0;
            peak     <= '0;
        end else if (clr) begin
            idx      <= '0;
            acc_sat  <= '0;
            acc_peak <= '0;
            win_done <= 1'b0;
        end else begin
            win_done <= 1'b0;
            if (valid) begin
                if (last) begin
                    idx      <= '0;
                    acc_sat  <= '0;
                    acc_peak <= '0;
                    sat_cnt  <= sat_nx;
                    peak     <= peak_nx;
                    win_done <= 1'b1;
                end else begin
                    idx      <= idx + 1'b1;
                    acc_sat  <= sat_nx;
                    acc_peak <= peak_nx;
                end
            end
        end
    end

    // R2: a closed window never reports more saturated samples than it holds
    p_sat_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> (int'(sat_cnt) <= WIN_LEN));

    // R2: a window result appears only after a valid sample
    p_done_after_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |-> $past(valid));

endmodule

// File: rtl/agc_step_sel.sv
module agc_step_sel
    import agc_pkg::*;
#(
    parameter int SAMP_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic [CNT_W-1:0]  sat_cnt,
    input  logic [SAMP_W-1:0] amp,
    input  logic [CNT_W-1:0]  sat_big_thr,
    input  logic [SAMP_W-1:0] lock_lo,
    input  logic [SAMP_W-1:0] lock_hi,
    output adj_e              adj
);
    always_comb begin
        if (sat_cnt != '0) begin
            adj = (sat_cnt >= sat_big_thr) ? ADJ_BIG : ADJ_MID;
        end else if (amp > lock_hi) begin
            adj = ADJ_FINE_DN;
        end else if (amp < lock_lo) begin
            adj = ADJ_FINE_UP;
        end else begin
            adj = ADJ_HOLD;
        end
    end

    // R6: a hold decision is only taken for an in-range, unsaturated window
    always_comb begin
        if (adj == ADJ_HOLD) begin
            p_hold_in_range_r6: assert (sat_cnt == '0 && amp >= lock_lo && amp <= lock_hi);
        end
    end

endmodule

// File: rtl/agc_gain_ctrl.sv
module agc_gain_ctrl
    import agc_pkg::*;
#(
    parameter int WIN_LEN   = 16,
    parameter int SAMP_W    = 8,
    parameter int RF_W      = 8,
    parameter int GAIN_W    = 7,
    parameter int GAIN_MIN  = 0,
    parameter int GAIN_MAX  = 90,
    parameter int BIG_STEP  = 12,
    parameter int MID_STEP  = 4,
    parameter int LNA_DB    = 30,
    parameter int CNT_W     = $clog2(WIN_LEN + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rx_en,
    input  logic                     samp_valid,
    input  logic signed [SAMP_W-1:0] samp,
    input  logic [RF_W-1:0]          rf_pwr,
    input  logic [CNT_W-1:0]         sat_big_thr,
    input  logic [SAMP_W-1:0]        lock_lo,
    input  logic [SAMP_W-1:0]        lock_hi,
    input  logic [SAMP_W-1:0]        drift_lim,
    input  logic [RF_W-1:0]          rf_off_thr,
    input  logic [RF_W-1:0]          rf_on_thr,
    output logic [GAIN_W-1:0]        if_gain,
    output logic                     lna_on,
    output logic                     locked,
    output logic                     cs_pulse
);
    localparam logic [GAIN_W-1:0] GAIN_TOP = GAIN_W'(GAIN_MAX);

    agc_state_e        st;
    agc_state_e        st_nx;
    logic              win_done;
    logic [CNT_W-1:0]  sat_cnt;
    logic [SAMP_W-1:0] amp;
    logic [SAMP_W-1:0] lock_amp;
    logic [SAMP_W-1:0] drift;
    logic              drift_over;
    logic              byp_req;
    logic              rst_req;
    adj_e              adj;

    agc_win_stats #(
        .WIN_LEN (WIN_LEN),
        .SAMP_W  (SAMP_W),
        .CNT_W   (CNT_W)
    ) u_stats (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!rx_en),
        .valid    (samp_valid),
        .samp     (samp),
        .win_done (win_done),
        .sat_cnt  (sat_cnt),
        .peak     (amp)
    );

    agc_step_sel #(
        .SAMP_W (SAMP_W),
        .CNT_W  (CNT_W)
    ) u_step (
        .sat_cnt     (sat_cnt),
        .amp         (amp),
        .sat_big_thr (sat_big_thr),
        .lock_lo     (lock_lo),
        .lock_hi     (lock_hi),
        .adj         (adj)
    );

    function automatic logic [GAIN_W-1:0] gain_dn(input logic [GAIN_W-1:0] g, input int d);
        int t;
        t = int'(g) - d;
        if (t < GAIN_MIN) t = GAIN_MIN;
        return GAIN_W'(t);
    endfunction

    function automatic logic [GAIN_W-1:0] gain_up(input logic [GAIN_W-1:0] g, input int d);
        int t;
        t = int'(g) + d;
        if (t > GAIN_MAX) t = GAIN_MAX;
        return GAIN_W'(t);
    endfunction

    always_comb begin
        drift      = (amp > lock_amp) ? (amp - lock_amp) : (lock_amp - amp);
        drift_over = drift > drift_lim;
        rst_req    = lna_on ? (rf_pwr >= rf_off_thr) : 1'b0;
        byp_req    = lna_on ? (rf_pwr >= rf_off_thr) : (rf_pwr < rf_on_thr);
    end

    // next state: start, lock, unlock, abort
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: if (rx_en) st_nx = S_ACQ;
            S_ACQ: begin
                if (!rx_en) st_nx = S_IDLE;
                else if (win_done && adj == ADJ_HOLD) st_nx = S_LOCK;
            end
            S_LOCK: begin
                if (!rx_en) st_nx = S_IDLE;
                else if (win_done && drift_over) st_nx = S_ACQ;
            end
            default: st_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            if_gain  <= GAIN_TOP;
            lna_on   <= 1'b1;
            locked   <= 1'b0;
            lock_amp <= '0;
            cs_pulse <= 1'b0;
        end else begin
            cs_pulse <= 1'b0;
            if (!rx_en) begin
                if_gain <= GAIN_TOP;
                lna_on  <= 1'b1;
                locked  <= 1'b0;
            end else begin
                unique case (st)
                    S_IDLE: begin
                        if_gain <= GAIN_TOP;
                        lna_on  <= 1'b1;
                        locked  <= 1'b0;
                    end
                    S_ACQ: begin
                        if (win_done) begin
                            if (adj == ADJ_HOLD) begin
                                locked   <= 1'b1;
                                lock_amp <= amp;
                            end else if (byp_req) begin
                                lna_on  <= !lna_on;
                                if_gain <= rst_req ? gain_up(if_gain, LNA_DB)
                                                   : gain_dn(if_gain, LNA_DB);
                            end else begin
                                unique case (adj)
                                    ADJ_BIG:     if_gain <= gain_dn(if_gain, BIG_STEP);
                                    ADJ_MID:     if_gain <= gain_dn(if_gain, MID_STEP);
                                    ADJ_FINE_DN: if_gain <= gain_dn(if_gain, 1);
                                    ADJ_FINE_UP: if_gain <= gain_up(if_gain, 1);
                                    default:     if_gain <= if_gain;
                                endcase
                            end
                        end
                    end
                    S_LOCK: begin
                        if (win_done && drift_over) begin
                            locked   <= 1'b0;
                            cs_pulse <= 1'b1;
                        end
                    end
                    default: begin
                        if_gain <= GAIN_TOP;
                        lna_on  <= 1'b1;
                        locked  <= 1'b0;
                    end
                endcase
            end
        end
    end

    // R1: receive disabled forces the start-up gain on the next cycle
    p_idle_values_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (if_gain == GAIN_TOP && lna_on && !locked && !cs_pulse));

    // R7: outputs move only after a closed window
    p_boundary_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && !win_done && st != S_IDLE) |=> ($stable(if_gain) && $stable(lna_on) && $stable(locked)));

    // R8: frozen gain and bypass while locked
    p_hold_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && rx_en) |=> ($stable(if_gain) && $stable(lna_on)));

    // R9: carrier-sense pulse accompanies a lock loss and lasts one cycle
    p_cs_on_unlock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_pulse |-> (!locked && $past(locked)));

    p_cs_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_pulse |=> !cs_pulse);

    // R13: gain code stays in range
    p_gain_range_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(if_gain) <= GAIN_MAX) && (int'(if_gain) >= GAIN_MIN));

endmodule

// File: tb/agc_gain_ctrl_test.sv
module agc_gain_ctrl_test;
    localparam int CLK_P    = 10;
    localparam int WIN_LEN  = 16;
    localparam int SAMP_W   = 8;
    localparam int RF_W     = 8;
    localparam int GAIN_W   = 7;
    localparam int CNT_W    = $clog2(WIN_LEN + 1);
    localparam int G_MAX    = 90;
    localparam int G_MIN    = 0;
    localparam int BIG_THR  = 6;
    localparam int LK_LO    = 40;
    localparam int LK_HI    = 70;
    localparam int DRIFT    = 10;
    localparam int RF_OFF   = 200;
    localparam int RF_ON    = 150;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     rx_en = 1'b0;
    logic                     samp_valid = 1'b0;
    logic signed [SAMP_W-1:0] samp = '0;
    logic [RF_W-1:0]          rf_pwr = 8'd100;
    logic [GAIN_W-1:0]        if_gain;
    logic                     lna_on;
    logic                     locked;
    logic                     cs_pulse;

    int checks = 0;
    int fails  = 0;
    int m_gain, m_lamp;
    bit m_lna, m_locked, m_cs;

    always #(CLK_P / 2) clk = ~clk;

    agc_gain_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_en       (rx_en),
        .samp_valid  (samp_valid),
        .samp        (samp),
        .rf_pwr      (rf_pwr),
        .sat_big_thr (CNT_W'(BIG_THR)),
        .lock_lo     (8'(LK_LO)),
        .lock_hi     (8'(LK_HI)),
        .drift_lim   (8'(DRIFT)),
        .rf_off_thr  (8'(RF_OFF)),
        .rf_on_thr   (8'(RF_ON)),
        .if_gain     (if_gain),
        .lna_on      (lna_on),
        .locked      (locked),
        .cs_pulse    (cs_pulse)
    );

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, "if_gain", int'(if_gain), m_gain);
        check(tag, "lna_on", int'(lna_on), int'(m_lna));
        check(tag, "locked", int'(locked), int'(m_locked));
        check(tag, "cs_pulse", int'(cs_pulse), int'(m_cs));
    endtask

    function automatic int clampg(input int g);
        if (g > G_MAX) return G_MAX;
        if (g < G_MIN) return G_MIN;
        return g;
    endfunction

    function automatic void model_reset();
        m_gain = G_MAX; m_lna = 1'b1; m_locked = 1'b0; m_cs = 1'b0; m_lamp = 0;
    endfunction

    function automatic void model_window(input int nsat, input int peak, input int rf);
        int amp, d;
        amp  = (nsat > 0) ? 127 : peak;
        m_cs = 1'b0;
        if (m_locked) begin
            d = (amp > m_lamp) ? amp - m_lamp : m_lamp - amp;
            if (d > DRIFT) begin m_locked = 1'b0; m_cs = 1'b1; end
        end else if (nsat == 0 && amp >= LK_LO && amp <= LK_HI) begin
            m_locked = 1'b1; m_lamp = amp;
        end else if (m_lna && rf >= RF_OFF) begin
            m_lna = 1'b0; m_gain = clampg(m_gain + 30);
        end else if (!m_lna && rf < RF_ON) begin
            m_lna = 1'b1; m_gain = clampg(m_gain - 30);
        end else if (nsat >= BIG_THR) m_gain = clampg(m_gain - 12);
        else if (nsat > 0)          m_gain = clampg(m_gain - 4);
        else if (amp > LK_HI)       m_gain = clampg(m_gain - 1);
        else                        m_gain = clampg(m_gain + 1);
    endfunction

    task automatic send_window(input int nsat, input int peak, input int rf, input string tag);
        int old_g, mag;
        old_g  = int'(if_gain);
        rf_pwr = RF_W'(rf);
        for (int i = 0; i < WIN_LEN; i++) begin
            @(negedge clk);
            samp_valid = 1'b1;
            if (i < nsat) mag = 127;
            else if (i == nsat) mag = ($urandom % 2) ? peak : -peak;
            else begin
                mag = int'($urandom % (peak + 1));
                if ($urandom % 2) mag = -mag;
            end
            samp = SAMP_W'(mag);
        end
        @(negedge clk);
        samp_valid = 1'b0;
        check("R7", "gain before update", int'(if_gain), old_g);
        @(negedge clk);
        model_window(nsat, peak, rf);
        check_all(tag);
    endtask

    task automatic drop_rx();
        @(negedge clk); rx_en = 1'b0;
        @(negedge clk); @(negedge clk);
        model_reset();
        check_all("R1");
        rx_en = 1'b1;
        @(negedge clk);
        check_all("R1");
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");
        rx_en = 1'b1;
        @(negedge clk); @(negedge clk);

        send_window(8, 0, 100, "R3");     // 90 -> 78
        send_window(3, 0, 100, "R4");     // 78 -> 74
        send_window(0, 100, 100, "R5");   // 74 -> 73
        send_window(0, 10, 100, "R5");    // 73 -> 74
        send_window(16, 0, 100, "R3");    // 74 -> 62
        send_window(6, 0, 100, "R3");     // exact threshold: 62 -> 50
        send_window(5, 0, 100, "R4");     // just under: 50 -> 46
        send_window(0, 100, 220, "R10");  // bypass: 46 -> 76
        send_window(0, 100, 170, "R11");  // hysteresis band: 76 -> 75
        send_window(0, 100, 100, "R11");  // restore: 75 -> 45
        send_window(0, 55, 220, "R12");   // lock wins over bypass
        send_window(0, 62, 220, "R8");    // drift 7, high power: held
        send_window(0, 65, 100, "R8");    // drift 10: held
        send_window(0, 45, 100, "R8");    // drift 10 below: held
        send_window(0, 66, 100, "R9");    // drift 11: unlock
        send_window(0, 100, 100, "R9");   // adjustment resumes
        send_window(0, 40, 100, "R6");    // lower edge locks
        send_window(0, 20, 100, "R9");    // unlock downward
        for (int k = 0; k < 6; k++) send_window(12, 0, 100, "R13");
        send_window(0, 71, 100, "R5");    // just above the range
        drop_rx();
        send_window(0, 10, 100, "R13");   // upper clamp at full gain
        send_window(0, 10, 220, "R13");   // bypass swap clamps at top
        send_window(0, 70, 100, "R6");    // upper edge locks

        for (int n = 0; n < 300; n++) begin
            int nsat, peak, rf;
            if ($urandom % 20 == 0) drop_rx();
            nsat = ($urandom % 2) ? 0 : int'($urandom % (WIN_LEN + 1));
            peak = int'($urandom % 127);
            rf   = int'($urandom % 256);
            if ($urandom % 3 == 0 && m_locked)
                peak = m_lamp + int'($urandom % 25) - 12;
            if (peak < 0) peak = 0;
            if (peak > 126) peak = 126;
            send_window(nsat, peak, rf, "R2");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule